// File: doc/BRIEF.md
# Real-Time Clock Interrupt Flag and Status Unit

This block keeps the interrupt state of a PC-style real-time clock. Three event sources feed it single-cycle pulses: a periodic tick, an alarm match and an update-ended notice. Each pulse latches a flag in the status register. The flag latches whether or not its enable is set. The host sets the enables by writing a control register. The host reads the status register through a simple register port, and that read clears every flag.

A summary bit in the status register, and an active-low interrupt pin, report only the flags whose enables are set. Each enable sits at the same bit position as its flag, so one mask serves both registers. A flag left stale while its enable was clear is still visible. It raises the interrupt as soon as its enable is set, unless a status read flushes it first. Time keeping and bus address decoding are done elsewhere. The ports here are plain strobes and data.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, all flags and all enables are zero: `stat_rdata` reads 8'h00, `ctl_rdata` reads 8'h00 and `irq_n` is 1.
- R2: A pulse on `evt_periodic`, `evt_alarm` or `evt_update` sets, in the next cycle, status bit 6, bit 5 or bit 4 respectively. This happens whatever the enables hold.
- R3: A set flag stays set through cycles that have no status read, including cycles with further events.
- R4: `stat_rdata` always shows the current status. A cycle with `stat_re` high returns the value held before the clear, and every flag is clear from the next cycle on.
- R5: An event pulse in the same cycle as a status read leaves that flag set after the read, so the event is not lost. Flags with no event in that cycle are cleared.
- R6: Status bit 7 equals (bit6 & periodic enable) | (bit5 & alarm enable) | (bit4 & update enable). Status bits 3..0 always read 0.
- R7: `irq_n` is 0 exactly when status bit 7 is 1. It changes in the same cycle as the status register.
- R8: A cycle with `ctl_we` high stores `ctl_wdata` bits 6 (periodic enable), 5 (alarm enable) and 4 (update enable). The other written bits are ignored and read as 0 on `ctl_rdata` from the next cycle on.
- R9: Setting an enable while its flag is already set raises bit 7 and pulls `irq_n` low in the next cycle. Clearing the enable drops both again and leaves the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register contents (enables only) |
| stat_re | input | 1 | Status read strobe; clears the flags |
| stat_rdata | output | 8 | Status register: summary, three flags, zeros |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can fall in the same cycle. A source pulse can arrive in the same cycle as the clearing status read. Separately, an enable write can land on a flag that is already pending. Directed steps drive an alarm pulse together with `stat_re` and expect only that flag, plus the summary bit, to survive. Other directed steps toggle the enables over stale flags. Random cycles then mix events, reads and writes freely, and every outcome is compared with a bench model of flags and enables.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int REG_W   = 8;
  localparam int SRC_N   = 3;  // index 0 update, 1 alarm, 2 periodic
  localparam int SRC_LSB = 4;  // lowest flag/enable bit
  localparam int SUM_BIT = 7;  // summary request bit

  function automatic logic [REG_W-1:0] src_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < SRC_N; i++) m[SRC_LSB+i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rtc_irq_flag.sv
module rtc_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o,
  output logic flag_nxt_o
);
  // an event in the clearing cycle wins
  always_comb flag_nxt_o = set_i | (flag_o & ~clr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_nxt_o;
  end

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o);
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [SRC_N-1:0] en_o,
  output logic [SRC_N-1:0] en_nxt_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam logic [REG_W-1:0] MASK = src_mask();

  always_comb en_nxt_o = we_i ? wdata_i[SRC_LSB +: SRC_N] : en_o;

  always_ff @(posedge clk) begin
    if (!rst_n) en_o <= '0;
    else        en_o <= en_nxt_o;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < SRC_N; i++) rdata_o[SRC_LSB+i] = en_o[i];
  end

  assert_ctl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (rdata_o == ($past(wdata_i) & MASK)));
endmodule

// File: rtl/rtc_irq_summary.sv
module rtc_irq_summary
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] flags_i,
  input  logic [SRC_N-1:0] en_i,
  input  logic [SRC_N-1:0] flags_nxt_i,
  input  logic [SRC_N-1:0] en_nxt_i,
  output logic             irqf_o,
  output logic             irq_n_o
);
  always_comb irqf_o = |(flags_i & en_i);

  // pin registered from next state: glitch-free and aligned with the flags
  always_ff @(posedge clk) begin
    if (!rst_n) irq_n_o <= 1'b1;
    else        irq_n_o <= ~|(flags_nxt_i & en_nxt_i);
  end

  assert_pin_tracks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n_o == !irqf_o);
  assert_stale_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_nxt_i & en_nxt_i)) |=> !irq_n_o);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_periodic,
  input  logic             evt_alarm,
  input  logic             evt_update,
  input  logic             ctl_we,
  input  logic [REG_W-1:0] ctl_wdata,
  output logic [REG_W-1:0] ctl_rdata,
  input  logic             stat_re,
  output logic [REG_W-1:0] stat_rdata,
  output logic             irq_n
);
  logic [SRC_N-1:0] evt_vec, flags, flags_nxt, en, en_nxt;
  logic             irqf;

  assign evt_vec = {evt_periodic, evt_alarm, evt_update};

  for (genvar g = 0; g < SRC_N; g++) begin : g_src
    rtc_irq_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (evt_vec[g]),
      .clr_i     (stat_re),
      .flag_o    (flags[g]),
      .flag_nxt_o(flags_nxt[g])
    );
  end

  rtc_irq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctl_we),
    .wdata_i (ctl_wdata),
    .en_o    (en),
    .en_nxt_o(en_nxt),
    .rdata_o (ctl_rdata)
  );

  rtc_irq_summary u_sum (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_i    (flags),
    .en_i       (en),
    .flags_nxt_i(flags_nxt),
    .en_nxt_i   (en_nxt),
    .irqf_o     (irqf),
    .irq_n_o    (irq_n)
  );

  always_comb begin
    stat_rdata = '0;
    stat_rdata[SUM_BIT] = irqf;
    for (int i = 0; i < SRC_N; i++) stat_rdata[SRC_LSB+i] = flags[i];
  end

  assert_collision_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_re && evt_alarm) |=> stat_rdata[5]);
  assert_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[SUM_BIT] == |(stat_rdata[6:4] & ctl_rdata[6:4]));
endmodule

// File: tb/rtc_irq_unit_test.sv
`timescale 1ns/1ps
module rtc_irq_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic evt_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic ctl_we = 0, stat_re = 0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata, stat_rdata;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  logic [2:0] m_flags = '0;  // {periodic, alarm, update}
  logic [2:0] m_en = '0;

  always #10 clk = ~clk;  // 50 MHz

  rtc_irq_unit uut (
    .clk(clk), .rst_n(rst_n),
    .evt_periodic(evt_periodic), .evt_alarm(evt_alarm), .evt_update(evt_update),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .stat_re(stat_re), .stat_rdata(stat_rdata), .irq_n(irq_n)
  );

  function automatic logic [7:0] exp_status(logic [2:0] f, logic [2:0] e);
    return {|(f & e), f, 4'b0000};
  endfunction

  function automatic logic [7:0] exp_ctl(logic [2:0] e);
    return {1'b0, e, 4'b0000};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_model(string tag);
    chk({tag, " status R6"}, stat_rdata, exp_status(m_flags, m_en));
    chk({tag, " pin R7"}, {7'd0, irq_n}, {7'd0, ~|(m_flags & m_en)});
    chk({tag, " ctl R8"}, ctl_rdata, exp_ctl(m_en));
  endtask

  // called at a falling edge; applies inputs for one cycle
  task automatic step(logic [2:0] ev, logic re, logic we, logic [7:0] wd);
    logic [2:0] nf, ne;
    {evt_periodic, evt_alarm, evt_update} = ev;
    stat_re = re; ctl_we = we; ctl_wdata = wd;
    nf = re ? ev : (m_flags | ev);
    ne = we ? wd[6:4] : m_en;
    @(posedge clk);
    @(negedge clk);
    {evt_periodic, evt_alarm, evt_update} = 3'b000;
    stat_re = 0; ctl_we = 0; ctl_wdata = '0;
    m_flags = nf; m_en = ne;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 status", stat_rdata, 8'h00);
    chk("R1 ctl", ctl_rdata, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    // R2 periodic latches with enable off
    step(3'b100, 0, 0, 8'h00);
    chk("R2 periodic", stat_rdata, 8'h40);
    chk("R2 irq_n idle", {7'd0, irq_n}, 8'h01);
    step(3'b011, 0, 0, 8'h00);
    chk("R2 alarm+update", stat_rdata, 8'h70);
    // R3 hold
    step(3'b000, 0, 0, 8'h00);
    chk("R3 hold", stat_rdata, 8'h70);
    // R8/R9 enable over stale flags
    step(3'b000, 0, 1, 8'hFF);
    chk("R8 ctl masked", ctl_rdata, 8'h70);
    chk("R9 stale raise", stat_rdata, 8'hF0);
    chk("R7 irq low", {7'd0, irq_n}, 8'h00);
    step(3'b000, 0, 1, 8'h8F);
    chk("R8 ignored bits", ctl_rdata, 8'h00);
    chk("R9 disable keeps flags", stat_rdata, 8'h70);
    chk("R9 irq high", {7'd0, irq_n}, 8'h01);
    // R4 read returns old value, then clears
    chk("R4 pre-read", stat_rdata, 8'h70);
    step(3'b000, 1, 0, 8'h00);
    chk("R4 cleared", stat_rdata, 8'h00);
    // R6 masking by alarm enable only
    step(3'b000, 0, 1, 8'h20);
    step(3'b001, 0, 0, 8'h00);
    chk("R6 unmasked update", stat_rdata, 8'h10);
    chk("R7 no irq", {7'd0, irq_n}, 8'h01);
    step(3'b010, 0, 0, 8'h00);
    chk("R6 alarm enabled", stat_rdata, 8'hB0);
    chk("R7 irq on alarm", {7'd0, irq_n}, 8'h00);
    // R5 event in clearing cycle
    step(3'b010, 1, 0, 8'h00);
    chk("R5 collision", stat_rdata, 8'hA0);
    chk("R5 irq kept", {7'd0, irq_n}, 8'h00);
    step(3'b000, 1, 0, 8'h00);
    chk("R4 final clear", stat_rdata, 8'h00);
    chk_model("directed end");
    // random phase against the model
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] ev;
      logic re, we;
      logic [7:0] wd;
      ev = {($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0};
      re = ($urandom % 6) == 0;
      we = ($urandom % 10) == 0;
      wd = 8'($urandom);
      step(ev, re, we, wd);
      chk_model("random R2 R3 R4 R5 R9");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule